// File: doc/BRIEF.md
# Successive Approximation Conversion Controller

This block is the digital half of a successive-approximation converter. It runs a binary search over an N-bit code, one bit per assertion of a step strobe. On every step it reads a one-bit comparator verdict. It settles the bit it tried on the step before, then raises the next lower trial bit. The trial code goes out in parallel to an external feedback DAC. Sample-and-hold, subtraction, comparison and conversion back to analog all stay outside the block.

A verdict always applies one step late, so the decision for the least significant bit arrives on the first step of the next conversion. On that step the block resolves the finished word into a result register and pulses a done flag for one cycle. An output DAC therefore receives exactly one completed word per sample period. The sample-and-hold may move to the next sample right after that step, because the first step of a conversion never consults the comparator for the new word.

Top module: `sar_ctrl`

## Requirements
- R1: A synchronous active-high reset drives trial_code, result and done to zero and points the search at the most significant bit.
- R2: A step taken while the search points at the most significant bit makes trial_code equal to 1 << (N-1), whatever was on cmp_in.
- R3: On a step that is not the first of a conversion, cmp_in = 0 clears the bit tried on the previous step and cmp_in = 1 keeps it.
- R4: Every step sets the bit at the current trial position in trial_code, and all bits below that position read zero.
- R5: In a cycle without step_en, trial_code, result and done-related state do not change, and cmp_in has no effect.
- R6: After the step that tries bit 0, the next step starts a fresh conversion at the most significant bit from a cleared working code.
- R7: On the first step after a completed conversion, result takes the last trial code with bit 0 kept if cmp_in = 1 and cleared if cmp_in = 0, and done is 1 for the following cycle.
- R8: done is high for exactly one clock per captured word and never on two consecutive cycles.
- R9: With a comparator that outputs 1 when the held input is at least trial_code, each captured result equals the held integer input, for every input from 0 to 2^N - 1.
- R10: The first step after reset captures nothing: done stays 0 and result stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step_en | input | 1 | Advances the search by one bit when high at a rising edge |
| cmp_in | input | 1 | Comparator verdict: 1 when the held input is at least trial_code |
| trial_code | output | N | Trial code driven to the feedback DAC |
| result | output | N | Last completed conversion word |
| done | output | 1 | One-cycle pulse when result takes a new word |

## Verification
A corrupted trial pointer shows on trial_code at the very next step, as a bit set in the wrong position or bits left below the trial bit. A stale or wrongly cleared working code shows as a wrong trial_code within one step, and as a wrong result one conversion later. The reference model is compared on every clock, so any of these faults is reported within one clock of the step that exposes it. The full input sweep with idle gaps between steps also catches verdicts that are taken late, taken without a step, or dropped on the least significant bit.

// File: rtl/sar_pkg.sv
package sar_pkg;

   // Implementation choice for the trial-position pointer
   typedef enum logic {
      PTR_ONEHOT = 1'b0,
      PTR_BINARY = 1'b1
   } ptr_style_e;

   localparam int unsigned SAR_MIN_BITS = 2;
   localparam int unsigned SAR_MAX_BITS = 24;

endpackage

// File: rtl/sar_trial_ptr.sv
module sar_trial_ptr
   import sar_pkg::*;
#(
   parameter int unsigned N         = 8,
   parameter ptr_style_e  PTR_STYLE = PTR_ONEHOT
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         adv,
   output logic [N-1:0] cur_w,
   output logic         at_msb,
   output logic         at_lsb
);
   localparam logic [N-1:0] MSB_W = N'(1) << (N - 1);
   localparam int unsigned  IDX_W = (N > 1) ? $clog2(N) : 1;
   localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(N - 1);

   generate
      if (PTR_STYLE == PTR_ONEHOT) begin : g_onehot
         logic [N-1:0] w_q;

         always_ff @(posedge clk) begin
            if (rst) begin
               w_q <= MSB_W;
            end else if (adv) begin
               w_q <= w_q[0] ? MSB_W : (w_q >> 1);
            end
         end

         assign cur_w  = w_q;
         assign at_msb = w_q[N-1];
         assign at_lsb = w_q[0];
      end else begin : g_binary
         logic [IDX_W-1:0] idx_q;

         always_ff @(posedge clk) begin
            if (rst) begin
               idx_q <= TOP_IDX;
            end else if (adv) begin
               idx_q <= (idx_q == '0) ? TOP_IDX : (idx_q - IDX_W'(1));
            end
         end

         always_comb begin
            cur_w = '0;
            for (int b = 0; b < N; b++) begin
               if (idx_q == IDX_W'(b)) cur_w[b] = 1'b1;
            end
         end

         assign at_msb = (idx_q == TOP_IDX);
         assign at_lsb = (idx_q == '0);
      end
   endgenerate

endmodule

// File: rtl/sar_code_reg.sv
module sar_code_reg #(
   parameter int unsigned N = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         step,
   input  logic         cmp,
   input  logic [N-1:0] cur_w,
   input  logic         at_msb,
   input  logic         at_lsb,
   output logic [N-1:0] trial_code
);
   logic [N-1:0] work_q;
   logic [N-1:0] code_q;
   logic [N-1:0] prev_w;
   logic [N-1:0] nxt;
   logic         drop_prev;

   // Bit tried on the previous step sits one position above the current one
   assign prev_w    = cur_w << 1;
   assign drop_prev = ~cmp & ~at_msb;

   genvar i;
   generate
      for (i = 0; i < N; i++) begin : g_slice
         logic kill;
         assign kill   = prev_w[i] & drop_prev;
         assign nxt[i] = cur_w[i] | (work_q[i] & ~kill);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         work_q <= '0;
         code_q <= '0;
      end else if (step) begin
         code_q <= nxt;
         work_q <= at_lsb ? '0 : nxt;
      end
   end

   assign trial_code = code_q;

endmodule

// File: rtl/sar_result_latch.sv
module sar_result_latch #(
   parameter int unsigned N = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         step,
   input  logic         cmp,
   input  logic         at_msb,
   input  logic         at_lsb,
   input  logic [N-1:0] trial_code,
   output logic [N-1:0] result,
   output logic         done
);
   logic         pend_q;
   logic [N-1:0] res_q;
   logic         done_q;
   logic         capture;

   // The LSB verdict arrives on the first step of the following conversion
   assign capture = step & at_msb & pend_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         pend_q <= 1'b0;
         res_q  <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= capture;
         if (capture) begin
            res_q  <= {trial_code[N-1:1], trial_code[0] & cmp};
            pend_q <= 1'b0;
         end else if (step & at_lsb) begin
            pend_q <= 1'b1;
         end
      end
   end

   assign result = res_q;
   assign done   = done_q;

endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl
   import sar_pkg::*;
#(
   parameter int unsigned N         = 8,
   parameter ptr_style_e  PTR_STYLE = PTR_ONEHOT
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         step_en,
   input  logic         cmp_in,
   output logic [N-1:0] trial_code,
   output logic [N-1:0] result,
   output logic         done
);
   generate
      if (N < SAR_MIN_BITS || N > SAR_MAX_BITS) begin : g_bad_width
         $error("sar_ctrl: N out of supported range");
      end
   endgenerate

   logic [N-1:0] cur_w;
   logic         at_msb;
   logic         at_lsb;
   logic [N-1:0] code_w;

   sar_trial_ptr #(.N(N), .PTR_STYLE(PTR_STYLE)) u_ptr (
      .clk    (clk),
      .rst    (rst),
      .adv    (step_en),
      .cur_w  (cur_w),
      .at_msb (at_msb),
      .at_lsb (at_lsb)
   );

   sar_code_reg #(.N(N)) u_code (
      .clk        (clk),
      .rst        (rst),
      .step       (step_en),
      .cmp        (cmp_in),
      .cur_w      (cur_w),
      .at_msb     (at_msb),
      .at_lsb     (at_lsb),
      .trial_code (code_w)
   );

   sar_result_latch #(.N(N)) u_res (
      .clk        (clk),
      .rst        (rst),
      .step       (step_en),
      .cmp        (cmp_in),
      .at_msb     (at_msb),
      .at_lsb     (at_lsb),
      .trial_code (code_w),
      .result     (result),
      .done       (done)
   );

   assign trial_code = code_w;

endmodule

// File: rtl/sar_ctrl_chk.sv
module sar_ctrl_chk #(
   parameter int unsigned N = 8
) (
   input logic         clk,
   input logic         rst,
   input logic         step_en,
   input logic         cmp_in,
   input logic [N-1:0] trial_code,
   input logic [N-1:0] result,
   input logic         done,
   input logic [N-1:0] cur_w,
   input logic         at_msb
);
   localparam logic [N-1:0] MSB_W = N'(1) << (N - 1);

   assert_ptr_onehot_R6: assert property (@(posedge clk) disable iff (rst)
      $countones(cur_w) == 1);

   assert_wrap_R6: assert property (@(posedge clk) disable iff (rst)
      step_en && cur_w[0] |=> at_msb);

   assert_msb_first_R2: assert property (@(posedge clk) disable iff (rst)
      step_en && at_msb |=> trial_code == MSB_W);

   assert_clear_prev_R3: assert property (@(posedge clk) disable iff (rst)
      step_en && !at_msb && !cmp_in |=> (trial_code & ($past(cur_w) << 1)) == '0);

   assert_set_cur_R4: assert property (@(posedge clk) disable iff (rst)
      step_en |=> (trial_code & $past(cur_w)) != '0);

   assert_low_clear_R4: assert property (@(posedge clk) disable iff (rst)
      step_en |=> (trial_code & ($past(cur_w) - N'(1))) == '0);

   assert_idle_stable_R5: assert property (@(posedge clk) disable iff (rst)
      !step_en |=> $stable(trial_code) && $stable(result) && !done);

   assert_done_after_step_R7: assert property (@(posedge clk) disable iff (rst)
      done |-> $past(step_en));

   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

endmodule

bind sar_ctrl sar_ctrl_chk #(.N(N)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .step_en    (step_en),
   .cmp_in     (cmp_in),
   .trial_code (trial_code),
   .result     (result),
   .done       (done),
   .cur_w      (cur_w),
   .at_msb     (at_msb)
);

// File: tb/tb_sar_ctrl.sv
module tb_sar_ctrl;
   localparam int N    = 8;
   localparam int FULL = 1 << N;

   logic         clk = 1'b0;
   logic         rst;
   logic         step_en;
   logic         cmp_in;
   logic [N-1:0] trial_code;
   logic [N-1:0] result;
   logic         done;

   int checks   = 0;
   int failures = 0;
   bit finished = 0;

   // Reference model state
   int    m_work, m_bit, m_code, m_res, m_done, m_pend;
   string m_tag;
   int    exp_q[$];
   int    captured = 0;

   always #5 clk = ~clk;

   sar_ctrl #(.N(N)) dut (
      .clk        (clk),
      .rst        (rst),
      .step_en    (step_en),
      .cmp_in     (cmp_in),
      .trial_code (trial_code),
      .result     (result),
      .done       (done)
   );

   task automatic chk(input string req, input int act, input int exp_v);
      checks++;
      if (act != exp_v) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp_v, $time);
      end
   endtask

   task automatic report();
      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   task automatic model(input logic r, input logic s, input logic c);
      int w;
      if (r) begin
         m_work = 0; m_bit = N - 1; m_code = 0; m_res = 0; m_done = 0; m_pend = 0;
         m_tag = "R1";
      end else begin
         m_done = 0;
         if (!s) begin
            m_tag = "R5";
         end else begin
            if (m_bit == N - 1) begin
               if (m_pend != 0) begin
                  m_res  = c ? m_code : (m_code & ~1);
                  m_done = 1;
                  m_pend = 0;
               end
               w = 0;
               m_tag = "R2 R6";
            end else begin
               w = m_work;
               if (!c) w = w & ~(1 << (m_bit + 1));
               m_tag = "R3 R4";
            end
            w = w | (1 << m_bit);
            m_code = w;
            if (m_bit == 0) begin
               m_work = 0; m_bit = N - 1; m_pend = 1;
            end else begin
               m_work = w; m_bit = m_bit - 1;
            end
         end
      end
   endtask

   task automatic tick(input logic r, input logic s, input logic c);
      rst = r; step_en = s; cmp_in = c;
      model(r, s, c);
      @(negedge clk);
      chk(m_tag, int'(trial_code), m_code);
      chk("R7", int'(result), m_res);
      chk("R8", int'(done), m_done);
      if (done) begin
         captured++;
         if (exp_q.size() == 0) chk("R9", 1, 0);
         else chk("R9", int'(result), exp_q.pop_front());
      end
   endtask

   initial begin
      int held, x_next, cyc;
      logic c;
      rst = 1'b1; step_en = 1'b0; cmp_in = 1'b0;
      model(1'b1, 1'b0, 1'b0);
      @(negedge clk);
      tick(1'b1, 1'b0, 1'b0);
      chk("R1", int'(trial_code), 0);
      chk("R1", int'(result), 0);
      chk("R1", int'(done), 0);

      // First step after reset: verdict has nothing to capture
      tick(1'b0, 1'b1, 1'b1);
      chk("R10", int'(done), 0);
      chk("R10", int'(result), 0);
      chk("R2", int'(trial_code), 1 << (N - 1));
      tick(1'b0, 1'b0, 1'b0);
      chk("R10", int'(done), 0);

      // Partial conversion, then idle with toggling comparator, then reset
      tick(1'b0, 1'b1, 1'b0);
      tick(1'b0, 1'b0, 1'b1);
      tick(1'b0, 1'b0, 1'b0);
      chk("R5", int'(trial_code), 1 << (N - 2));
      tick(1'b0, 1'b1, 1'b1);
      tick(1'b1, 1'b1, 1'b1);
      chk("R1", int'(trial_code), 0);
      chk("R1", int'(done), 0);

      // Full sweep of held inputs with idle gaps between some steps
      held = 0; x_next = 0; cyc = 0;
      while (captured < FULL && !finished) begin
         cyc++;
         if ((cyc % 4) == 3) begin
            tick(1'b0, 1'b0, cyc[3]);
         end else begin
            c = (held >= int'(trial_code));
            if (m_bit == N - 1) begin
               if (m_pend != 0) exp_q.push_back(held);
               tick(1'b0, 1'b1, c);
               if (x_next < FULL) begin
                  held = x_next;
                  x_next++;
               end
            end else begin
               tick(1'b0, 1'b1, c);
            end
         end
      end
      chk("R9", captured, FULL);
      report();
   end

   initial begin
      #2ms;
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=timeout expected=completion");
         report();
      end
   end

endmodule